// File: doc/BRIEF.md
# Latched interrupt status unit

This unit gathers the one-cycle event pulses produced by a motion sensor's detection engines (tap, tilt, wake-up, back-to-sleep, free-fall, data-ready) and by its sample buffer (full and watermark). It holds each event in a sticky bit until software reads the register that clears it. The held bits are shown as three source bytes and one combined status byte, and a single level interrupt line is driven from them. Each bit has its own clear condition. The dedicated release register clears most of the bits. A read of the acceleration output clears data-ready. A buffer read clears buffer-full, and it clears the watermark bit only once the buffer level has dropped to the watermark.

The host read path supplies one strobe for each kind of read, plus a flag that marks the first byte of an auto-increment burst. A read of the release register clears anything only when it is that first byte. The event detectors and the buffer storage sit outside the unit. The unit sees the buffer only through its level, its watermark setting and a trigger-mode flag.

Top module: `irq_latch_unit`

## Requirements
- R1: `src_tap_o` bits 5..0 accumulate (OR) the tap direction bits of each valid tap. The bits map one to one from `tap_dir`, and the order from bit 5 down to bit 0 is X-, X+, Y-, Y+, Z-, Z+. Bits 7:6 read 0.
- R2: `src_evt_o[3:2]` holds the kind of the most recent valid tap: 01 for a single tap, 10 for a double tap, and 00 when no tap is held. A tap pulse with kind 00 or 11 is ignored entirely, so neither the direction bits nor the kind change.
- R3: `src_evt_o` carries bit 7 for free-fall, bit 6 for buffer full, bit 5 for watermark, bit 4 for data ready and bit 0 for tilt change. Bit 1 reads 0.
- R4: `src_motion_o` carries bit 7 for wake-up and bit 6 for back-to-sleep. Bits 5..0 accumulate `motion_dir` on each wake-up pulse, in the same axis order as R1.
- R5: A release read with `rel_burst_start`=1 clears `src_tap_o`, `src_motion_o`, the tap kind, tilt, free-fall and data ready. Buffer full and watermark are left unchanged.
- R6: A release read with `rel_burst_start`=0 has no effect on any latched bit.
- R7: Data ready is cleared by `data_rd`.
- R8: Buffer full is cleared by `buf_rd` and by nothing else.
- R9: The watermark bit sets when `buf_level` rises to or above a non-zero `buf_wmark`. It clears on `buf_rd` only if `buf_level <= buf_wmark` in that cycle. While `trig_mode`=1 it is held at 0 and never sets.
- R10: An event pulse that arrives in the same cycle as a clear of its bit wins, and the bit stays set.
- R11: `irq_o` is the OR of the held groups whose `irq_mask` bit is 1: bit 0 tilt, bit 1 tap (kind non-zero), bit 2 data ready, bit 3 watermark, bit 4 buffer full, bit 5 free-fall, bit 6 back-to-sleep, bit 7 wake-up. `status_o[4]` equals `irq_o`.
- R12: `status_o[0]` is the wake state. It is 1 after reset, a back-to-sleep pulse makes it 0, and a wake-up pulse makes it 1 (wake-up wins if both arrive together). The other status bits read 0.
- R13: After reset all source bytes are 0x00 and `irq_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tap_evt | input | 1 | Tap detected pulse |
| tap_kind | input | 2 | Tap kind with the pulse (01 single, 10 double) |
| tap_dir | input | 6 | Tap direction bits |
| tilt_evt | input | 1 | Tilt position changed pulse |
| wake_evt | input | 1 | Wake-up pulse |
| sleep_evt | input | 1 | Back-to-sleep pulse |
| motion_dir | input | 6 | Motion direction bits with the wake-up pulse |
| ff_evt | input | 1 | Free-fall pulse |
| drdy_evt | input | 1 | New output data pulse |
| buf_full_evt | input | 1 | Buffer became full pulse |
| buf_level | input | LVL_W | Current buffer sample count |
| buf_wmark | input | LVL_W | Buffer watermark setting |
| trig_mode | input | 1 | Buffer runs in trigger mode |
| irq_mask | input | 8 | Interrupt enable per group (R11) |
| rel_rd | input | 1 | Release register read strobe |
| rel_burst_start | input | 1 | Current read byte starts a burst |
| data_rd | input | 1 | Acceleration output read strobe |
| buf_rd | input | 1 | Buffer sample read strobe |
| src_tap_o | output | 8 | Tap direction source byte |
| src_evt_o | output | 8 | Event source byte |
| src_motion_o | output | 8 | Wake/sleep/motion source byte |
| status_o | output | 8 | Combined status byte |
| irq_o | output | 1 | Level interrupt |

## Verification
The bench sweeps every tap direction against every kind code. A design that accepts the undefined kinds would latch directions or show 11 in the kind field. Every mask value is crossed with every single held group, which exposes a mask bit routed to the wrong group or a group that is never gated. The watermark is swept over every setting of a 4-bit buffer. The sweep checks the set on reaching the watermark, a buffer read above the watermark (the bit must survive) and a read at the watermark (it must clear). An off-by-one compare there either clears early or never clears. Release reads in mid-burst, set-versus-clear collisions and the buffer bits' immunity to a release read are each driven directly. A design that gave clears priority, or cleared buffer bits on release, would drop a bit the bench expects to see.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int DIR_W  = 6;
    localparam int MASK_W = 8;

    // flat flag vector layout
    localparam int F_TAP0  = 0;
    localparam int F_MOT0  = F_TAP0 + DIR_W;
    localparam int F_TILT  = F_MOT0 + DIR_W;
    localparam int F_DRDY  = F_TILT + 1;
    localparam int F_WMK   = F_DRDY + 1;
    localparam int F_BFULL = F_WMK + 1;
    localparam int F_FF    = F_BFULL + 1;
    localparam int F_SLEEP = F_FF + 1;
    localparam int F_WAKE  = F_SLEEP + 1;
    localparam int NFLAG   = F_WAKE + 1;

    typedef enum logic [1:0] {
        TAP_NONE   = 2'b00,
        TAP_SINGLE = 2'b01,
        TAP_DOUBLE = 2'b10,
        TAP_BAD    = 2'b11
    } tap_kind_e;

    typedef struct packed {
        tap_kind_e kind;
        logic      awake;
    } top_state_t;
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] q_o
);
    logic [N-1:0] flags_d, flags_q;

    // set beats clear in the same cycle
    for (genvar i = 0; i < N; i++) begin : g_bit
        assign flags_d[i] = set_i[i] | (flags_q[i] & ~clr_i[i]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    assign q_o = flags_q;
endmodule

// File: rtl/irq_wmark_det.sv
module irq_wmark_det #(
    parameter int LVL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] level_i,
    input  logic [LVL_W-1:0] wmark_i,
    input  logic             trig_i,
    output logic             set_o
);
    typedef struct packed {
        logic reached;
    } wm_state_t;

    wm_state_t st_d, st_q;
    logic      reach_now;

    always_comb begin
        reach_now      = (wmark_i != '0) && (level_i >= wmark_i);
        st_d.reached   = reach_now;
        set_o          = reach_now && !st_q.reached && !trig_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/irq_clear_ctrl.sv
module irq_clear_ctrl
    import irq_pkg::*;
#(
    parameter int LVL_W = 8
) (
    input  logic             rel_rd_i,
    input  logic             rel_first_i,
    input  logic             data_rd_i,
    input  logic             buf_rd_i,
    input  logic             trig_i,
    input  logic [LVL_W-1:0] level_i,
    input  logic [LVL_W-1:0] wmark_i,
    output logic [NFLAG-1:0] clr_o,
    output logic             rel_hit_o
);
    always_comb begin
        rel_hit_o = rel_rd_i && rel_first_i;
        for (int i = 0; i < NFLAG; i++) begin
            clr_o[i] = rel_hit_o && (i != F_WMK) && (i != F_BFULL);
        end
        clr_o[F_DRDY]  = clr_o[F_DRDY] | data_rd_i;
        clr_o[F_BFULL] = buf_rd_i;
        clr_o[F_WMK]   = (buf_rd_i && (level_i <= wmark_i)) || trig_i;
    end
endmodule

// File: rtl/irq_latch_unit.sv
module irq_latch_unit
    import irq_pkg::*;
#(
    parameter int LVL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tap_evt,
    input  logic [1:0]       tap_kind,
    input  logic [5:0]       tap_dir,
    input  logic             tilt_evt,
    input  logic             wake_evt,
    input  logic             sleep_evt,
    input  logic [5:0]       motion_dir,
    input  logic             ff_evt,
    input  logic             drdy_evt,
    input  logic             buf_full_evt,
    input  logic [LVL_W-1:0] buf_level,
    input  logic [LVL_W-1:0] buf_wmark,
    input  logic             trig_mode,
    input  logic [7:0]       irq_mask,
    input  logic             rel_rd,
    input  logic             rel_burst_start,
    input  logic             data_rd,
    input  logic             buf_rd,
    output logic [7:0]       src_tap_o,
    output logic [7:0]       src_evt_o,
    output logic [7:0]       src_motion_o,
    output logic [7:0]       status_o,
    output logic             irq_o
);
    logic [NFLAG-1:0]  set_v, clr_v, flags;
    logic              wmk_set, rel_hit, tap_ok;
    logic [MASK_W-1:0] groups;
    top_state_t        st_d, st_q;

    irq_wmark_det #(.LVL_W(LVL_W)) u_wmark (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (buf_level),
        .wmark_i (buf_wmark),
        .trig_i  (trig_mode),
        .set_o   (wmk_set)
    );

    irq_clear_ctrl #(.LVL_W(LVL_W)) u_clear (
        .rel_rd_i    (rel_rd),
        .rel_first_i (rel_burst_start),
        .data_rd_i   (data_rd),
        .buf_rd_i    (buf_rd),
        .trig_i      (trig_mode),
        .level_i     (buf_level),
        .wmark_i     (buf_wmark),
        .clr_o       (clr_v),
        .rel_hit_o   (rel_hit)
    );

    irq_flag_bank #(.N(NFLAG)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (set_v),
        .clr_i (clr_v),
        .q_o   (flags)
    );

    always_comb begin
        tap_ok = tap_evt && ((tap_kind == TAP_SINGLE) || (tap_kind == TAP_DOUBLE));

        set_v                       = '0;
        set_v[F_TAP0 +: DIR_W]      = tap_ok   ? tap_dir    : '0;
        set_v[F_MOT0 +: DIR_W]      = wake_evt ? motion_dir : '0;
        set_v[F_TILT]               = tilt_evt;
        set_v[F_DRDY]               = drdy_evt;
        set_v[F_WMK]                = wmk_set;
        set_v[F_BFULL]              = buf_full_evt;
        set_v[F_FF]                 = ff_evt;
        set_v[F_SLEEP]              = sleep_evt;
        set_v[F_WAKE]               = wake_evt;

        st_d = st_q;
        if (tap_ok)       st_d.kind = tap_kind_e'(tap_kind);
        else if (rel_hit) st_d.kind = TAP_NONE;
        if (wake_evt)       st_d.awake = 1'b1;
        else if (sleep_evt) st_d.awake = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.kind  <= TAP_NONE;
            st_q.awake <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        groups = {flags[F_WAKE], flags[F_SLEEP], flags[F_FF], flags[F_BFULL],
                  flags[F_WMK], flags[F_DRDY], (st_q.kind != TAP_NONE), flags[F_TILT]};
        irq_o        = |(groups & irq_mask);
        src_tap_o    = {2'b00, flags[F_TAP0 +: DIR_W]};
        src_evt_o    = {flags[F_FF], flags[F_BFULL], flags[F_WMK], flags[F_DRDY],
                        st_q.kind, 1'b0, flags[F_TILT]};
        src_motion_o = {flags[F_WAKE], flags[F_SLEEP], flags[F_MOT0 +: DIR_W]};
        status_o     = {3'b000, irq_o, 3'b000, st_q.awake};
    end
endmodule

// File: rtl/irq_latch_chk.sv
module irq_latch_chk #(
    parameter int LVL_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tap_evt,
    input logic [1:0]       tap_kind,
    input logic             wake_evt,
    input logic             sleep_evt,
    input logic             drdy_evt,
    input logic             trig_mode,
    input logic [7:0]       irq_mask,
    input logic             rel_rd,
    input logic             rel_burst_start,
    input logic             data_rd,
    input logic             buf_rd,
    input logic [7:0]       src_tap_o,
    input logic [7:0]       src_evt_o,
    input logic [7:0]       src_motion_o,
    input logic [7:0]       status_o,
    input logic             irq_o
);
    // R2: an undefined tap kind leaves the kind field unchanged
    p_bad_kind_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tap_evt && tap_kind == 2'b11 && !rel_rd) |=> $stable(src_evt_o[3:2]));

    // R5: release read at burst start empties the tap and motion bytes
    p_rel_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_rd && rel_burst_start && !tap_evt && !wake_evt && !sleep_evt)
        |=> (src_tap_o == 8'h00 && src_motion_o == 8'h00));

    // R6: release read in mid-burst drops no tap or motion bit
    p_mid_burst_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_rd && !rel_burst_start)
        |=> (((src_tap_o & $past(src_tap_o)) == $past(src_tap_o)) &&
             ((src_motion_o & $past(src_motion_o)) == $past(src_motion_o))));

    // R7: data read clears data ready
    p_drdy_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && !drdy_evt) |=> !src_evt_o[4]);

    // R8: buffer full survives anything but a buffer read
    p_bfull_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (src_evt_o[6] && !buf_rd) |=> src_evt_o[6]);

    // R9: trigger mode keeps the watermark bit low
    p_trig_wmk_r9: assert property (@(posedge clk) disable iff (!rst_n)
        trig_mode |=> !src_evt_o[5]);

    // R10: a new event beats a simultaneous clear
    p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        drdy_evt |=> src_evt_o[4]);

    // R11: no enabled group means no interrupt
    p_mask_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_mask == 8'h00) |-> !irq_o);

    // R12: wake state follows wake and sleep pulses
    p_wake_r12: assert property (@(posedge clk) disable iff (!rst_n)
        wake_evt |=> status_o[0]);
    p_sleep_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_evt && !wake_evt) |=> !status_o[0]);
endmodule

bind irq_latch_unit irq_latch_chk #(.LVL_W(LVL_W)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .tap_evt         (tap_evt),
    .tap_kind        (tap_kind),
    .wake_evt        (wake_evt),
    .sleep_evt       (sleep_evt),
    .drdy_evt        (drdy_evt),
    .trig_mode       (trig_mode),
    .irq_mask        (irq_mask),
    .rel_rd          (rel_rd),
    .rel_burst_start (rel_burst_start),
    .data_rd         (data_rd),
    .buf_rd          (buf_rd),
    .src_tap_o       (src_tap_o),
    .src_evt_o       (src_evt_o),
    .src_motion_o    (src_motion_o),
    .status_o        (status_o),
    .irq_o           (irq_o)
);

// File: tb/irq_latch_unit_test.sv
module irq_latch_unit_test;
    localparam int LW = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          tap_evt, tilt_evt, wake_evt, sleep_evt, ff_evt, drdy_evt, buf_full_evt;
    logic [1:0]    tap_kind;
    logic [5:0]    tap_dir, motion_dir;
    logic [LW-1:0] buf_level, buf_wmark;
    logic          trig_mode, rel_rd, rel_burst_start, data_rd, buf_rd;
    logic [7:0]    irq_mask;
    logic [7:0]    src_tap_o, src_evt_o, src_motion_o, status_o;
    logic          irq_o;

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    irq_latch_unit #(.LVL_W(LW)) uut (
        .clk(clk), .rst_n(rst_n),
        .tap_evt(tap_evt), .tap_kind(tap_kind), .tap_dir(tap_dir),
        .tilt_evt(tilt_evt), .wake_evt(wake_evt), .sleep_evt(sleep_evt),
        .motion_dir(motion_dir), .ff_evt(ff_evt), .drdy_evt(drdy_evt),
        .buf_full_evt(buf_full_evt), .buf_level(buf_level), .buf_wmark(buf_wmark),
        .trig_mode(trig_mode), .irq_mask(irq_mask),
        .rel_rd(rel_rd), .rel_burst_start(rel_burst_start),
        .data_rd(data_rd), .buf_rd(buf_rd),
        .src_tap_o(src_tap_o), .src_evt_o(src_evt_o), .src_motion_o(src_motion_o),
        .status_o(status_o), .irq_o(irq_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        tap_evt = 0; tap_kind = 0; tap_dir = 0; tilt_evt = 0; wake_evt = 0;
        sleep_evt = 0; motion_dir = 0; ff_evt = 0; drdy_evt = 0; buf_full_evt = 0;
        rel_rd = 0; rel_burst_start = 0; data_rd = 0; buf_rd = 0;
    endtask

    // inputs are set at a negedge; one posedge passes; back at a negedge
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        idle();
    endtask

    task automatic clr_all();
        rel_rd = 1; rel_burst_start = 1; buf_rd = 1; buf_level = 0;
        step();
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        idle();
        buf_level = 0; buf_wmark = 0; trig_mode = 0; irq_mask = 0;
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R13 / R12 reset state
        chk("R13 src_tap", src_tap_o, 8'h00);
        chk("R13 src_evt", src_evt_o, 8'h00);
        chk("R13 src_motion", src_motion_o, 8'h00);
        chk("R12 status after reset", status_o, 8'h01);
        irq_mask = 8'hFF; #1;
        chk("R13 irq", irq_o, 0);
        irq_mask = 0;

        // R1 R2 sweep of all directions and kinds
        for (int d = 0; d < 64; d++) begin
            for (int k = 0; k < 4; k++) begin
                clr_all();
                tap_evt = 1; tap_dir = d[5:0]; tap_kind = k[1:0];
                step();
                if (k == 1 || k == 2) begin
                    chk("R1 tap dir", src_tap_o, {2'b00, d[5:0]});
                    chk("R2 tap kind", src_evt_o[3:2], k[1:0]);
                end else begin
                    chk("R2 bad kind ignored dir", src_tap_o, 8'h00);
                    chk("R2 bad kind ignored kind", src_evt_o[3:2], 2'b00);
                end
            end
        end

        // R1 accumulation, R2 last kind wins
        clr_all();
        tap_evt = 1; tap_kind = 2'b01; tap_dir = 6'h21; step();
        tap_evt = 1; tap_kind = 2'b10; tap_dir = 6'h06; step();
        chk("R1 accumulate", src_tap_o, 8'h27);
        chk("R2 last kind", src_evt_o[3:2], 2'b10);
        tap_evt = 1; tap_kind = 2'b11; tap_dir = 6'h10; step();
        chk("R2 undefined keeps dir", src_tap_o, 8'h27);
        chk("R2 undefined keeps kind", src_evt_o[3:2], 2'b10);

        // R4 motion sweep
        for (int d = 0; d < 64; d++) begin
            clr_all();
            wake_evt = 1; motion_dir = d[5:0]; step();
            chk("R4 motion", src_motion_o, {2'b10, d[5:0]});
        end
        clr_all();
        sleep_evt = 1; step();
        chk("R4 sleep bit", src_motion_o, 8'h40);

        // R3 field positions
        clr_all();
        ff_evt = 1; step();
        chk("R3 free-fall bit7", src_evt_o, 8'h80);
        clr_all();
        buf_full_evt = 1; step();
        chk("R3 full bit6", src_evt_o, 8'h40);
        clr_all();
        drdy_evt = 1; step();
        chk("R3 drdy bit4", src_evt_o, 8'h10);
        clr_all();
        tilt_evt = 1; step();
        chk("R3 tilt bit0", src_evt_o, 8'h01);
        clr_all();
        buf_wmark = 3; buf_level = 3; step();
        chk("R3 wmk bit5", src_evt_o, 8'h20);

        // R5 R6 release reads
        clr_all();
        tap_evt = 1; tap_kind = 1; tap_dir = 6'h3F; tilt_evt = 1; ff_evt = 1;
        drdy_evt = 1; buf_full_evt = 1; wake_evt = 1; motion_dir = 6'h15;
        buf_wmark = 2; buf_level = 2; step();
        chk("R5 setup evt", src_evt_o, 8'hF5);
        rel_rd = 1; rel_burst_start = 0; step();
        chk("R6 mid-burst tap", src_tap_o, 8'h3F);
        chk("R6 mid-burst evt", src_evt_o, 8'hF5);
        chk("R6 mid-burst motion", src_motion_o, 8'h95);
        rel_rd = 1; rel_burst_start = 1; step();
        chk("R5 release tap", src_tap_o, 8'h00);
        chk("R5 release evt keeps buffer bits", src_evt_o, 8'h60);
        chk("R5 release motion", src_motion_o, 8'h00);

        // R8 buffer full
        buf_level = 0; buf_rd = 1; step();
        chk("R8 full cleared by buffer read", src_evt_o[6], 0);

        // R7 data ready
        clr_all();
        drdy_evt = 1; step();
        data_rd = 1; step();
        chk("R7 drdy cleared by data read", src_evt_o[4], 0);

        // R10 collisions
        drdy_evt = 1; data_rd = 1; step();
        chk("R10 drdy set beats data read", src_evt_o[4], 1);
        clr_all();
        tap_evt = 1; tap_kind = 2; tap_dir = 6'h01; rel_rd = 1; rel_burst_start = 1; step();
        chk("R10 tap beats release", src_tap_o, 8'h01);
        chk("R10 tap kind beats release", src_evt_o[3:2], 2'b10);
        buf_full_evt = 1; buf_rd = 1; step();
        chk("R10 full beats buffer read", src_evt_o[6], 1);

        // R9 watermark sweep
        for (int w = 1; w < 16; w++) begin
            buf_wmark = w[LW-1:0];
            buf_level = 0; buf_rd = 1; step();
            chk("R9 cleared", src_evt_o[5], 0);
            buf_level = LW'(w - 1); step();
            chk("R9 below mark", src_evt_o[5], 0);
            buf_level = w[LW-1:0]; step();
            chk("R9 reached", src_evt_o[5], 1);
            if (w < 15) begin
                buf_level = LW'(w + 1); buf_rd = 1; step();
                chk("R9 read above mark keeps", src_evt_o[5], 1);
            end
            buf_level = w[LW-1:0]; buf_rd = 1; step();
            chk("R9 read at mark clears", src_evt_o[5], 0);
            buf_level = 0; step();
        end
        buf_wmark = 0; buf_level = 5; step();
        chk("R9 zero mark never sets", src_evt_o[5], 0);
        buf_level = 0; trig_mode = 1; buf_wmark = 2; step();
        buf_level = 4; step();
        chk("R9 trigger mode blocks", src_evt_o[5], 0);
        trig_mode = 0; buf_level = 0; step();

        // R11 mask sweep per group
        for (int g = 0; g < 8; g++) begin
            irq_mask = 0;
            clr_all();
            case (g)
                0: tilt_evt = 1;
                1: begin tap_evt = 1; tap_kind = 1; end
                2: drdy_evt = 1;
                3: begin buf_wmark = 2; buf_level = 2; end
                4: buf_full_evt = 1;
                5: ff_evt = 1;
                6: sleep_evt = 1;
                default: wake_evt = 1;
            endcase
            step();
            for (int m = 0; m < 256; m++) begin
                irq_mask = m[7:0]; #1;
                chk("R11 irq mask", irq_o, m[g]);
                chk("R11 status bit4", status_o[4], m[g]);
            end
        end
        irq_mask = 0;

        // R12 wake state
        clr_all();
        sleep_evt = 1; step();
        chk("R12 sleep clears wake", status_o, 8'h00);
        wake_evt = 1; step();
        chk("R12 wake sets", status_o, 8'h01);
        sleep_evt = 1; wake_evt = 1; step();
        chk("R12 both -> awake", status_o[0], 1);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule